// File: doc/BRIEF.md
# Modular Double-to-Int32 Converter

This block turns an IEEE binary64 operand into a signed 32-bit integer the way the ToInt32 operation of a widely used scripting language does. The value is first truncated toward zero. The integer part is then reduced modulo 2^32 instead of being clamped to the int32 range. The 32-bit pattern that results is sign-extended into a 64-bit destination, so a register write needs no further adjustment.

An operand is presented together with a one-cycle valid strobe. The result, an invalid flag and an inexact flag appear one clock later, together with an output valid strobe. Infinities and NaNs produce zero. The integer part is formed with a shifter wide enough to hold every integer bit that can still reach the low 32 bits, so bits above 2^31 are dropped correctly rather than saturated.

Top module: `cvtw_mod_int32`

## Requirements
- R1: Conversion always truncates toward zero: 2.75 gives 2 and -1.5 gives -1. No other rounding mode is applied.
- R2: The low word of the result is bits 31:0 of the exact truncated integer magnitude, whatever its width. For example, 2^40 + 7 gives 7.
- R3: Output bits 63:32 are copies of output bit 31.
- R4: For a negative input, the low word is the two's complement of the magnitude's low 32 bits. For example, -1.5 gives 0xFFFFFFFFFFFFFFFF.
- R5: An exponent field of all ones (+inf, -inf, any NaN) gives result 0, invalid 1, inexact 0.
- R6: Both zeros give result 0 with no flags. A nonzero subnormal gives result 0, invalid 0, inexact 1.
- R7: A finite input whose truncated value lies outside -2^31..2^31-1 raises invalid, and the wrapped result is still delivered. For example, 2^31 gives 0xFFFFFFFF80000000 with invalid 1, while -2^31 gives the same value with invalid 0.
- R8: Inexact is 1 exactly when invalid is 0 and truncation discarded a nonzero fraction.
- R9: A finite input of magnitude 2^84 or more gives result 0 with invalid 1 and inexact 0.
- R10: Results appear on the clock edge after the edge that samples in_valid=1, with out_valid high for exactly that one cycle. While in_valid is 0, out_res and the flags hold their values.
- R11: During reset, out_valid, out_res, out_invalid and out_inexact are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | binary64 operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_res | output | 64 | Wrapped int32, sign-extended to 64 bits |
| out_invalid | output | 1 | Non-finite input or int32 range exceeded |
| out_inexact | output | 1 | Nonzero fraction discarded, valid result |

## Verification
Every result, flag and strobe is due exactly one clock edge after the edge that samples in_valid. The bench drives an operand on a falling edge and compares all four outputs on the next falling edge, half a period after the capturing rising edge, so that no check samples at an edge. Hold behaviour is checked by idling several cycles while in_op changes and confirming that out_valid stays low and the result does not move. The sweeps run scaled odd mantissas over exponents 0 to 100 in both signs, plus fractional offsets around the int32 boundaries. Expected words are built from a 192-bit integer product in the bench.

// File: rtl/cvtw_pkg.sv
package cvtw_pkg;
  localparam int FP_EXP_W  = 11;
  localparam int FP_FRAC_W = 52;
  localparam int TGT_INT_W = 32;
  localparam int DST_W     = 64;

  typedef enum logic [1:0] {
    CLS_ZERO,
    CLS_SUBN,
    CLS_NORM,
    CLS_SPEC
  } fp_cls_e;
endpackage

// File: rtl/cvtw_unpack.sv
module cvtw_unpack
  import cvtw_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0]   op,
  output fp_cls_e                 cls,
  output logic                    sign,
  output logic signed [EXP_W+1:0] exp_unb,
  output logic [FRAC_W:0]         sig
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign   = op[EXP_W+FRAC_W];
  assign exp_f  = op[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = op[FRAC_W-1:0];

  always_comb begin
    exp_unb = $signed({2'b00, exp_f}) - $signed((EXP_W+2)'(BIAS));
    sig     = {1'b1, frac_f};
    if (&exp_f)              cls = CLS_SPEC;
    else if (exp_f != '0)    cls = CLS_NORM;
    else if (frac_f != '0)   cls = CLS_SUBN;
    else                     cls = CLS_ZERO;
  end
endmodule

// File: rtl/cvtw_wrap_shift.sv
module cvtw_wrap_shift
  import cvtw_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W,
  parameter int INT_W  = TGT_INT_W
) (
  input  fp_cls_e                 cls,
  input  logic signed [EXP_W+1:0] exp_unb,
  input  logic [FRAC_W:0]         sig,
  output logic [INT_W-1:0]        mag_lo,
  output logic                    mag_big,
  output logic                    mag_is_min,
  output logic                    frac_nz
);
  localparam int SHIFT_MAX = FRAC_W + INT_W;
  localparam int EXT_W     = FRAC_W + SHIFT_MAX;
  localparam int SH_W      = $clog2(SHIFT_MAX);

  logic [EXT_W-1:0]     ext;
  logic [SHIFT_MAX-1:0] int_part;
  logic                 too_big;
  logic                 below_one;
  logic [SH_W-1:0]      sh;

  assign sh = exp_unb[SH_W-1:0];

  always_comb begin
    ext       = '0;
    too_big   = 1'b0;
    below_one = 1'b0;
    if (cls == CLS_SUBN) begin
      below_one = 1'b1;
    end else if (cls == CLS_NORM) begin
      if (exp_unb < 0)
        below_one = 1'b1;
      else if (exp_unb >= $signed((EXP_W+2)'(SHIFT_MAX)))
        too_big = 1'b1;
      else
        ext = EXT_W'(sig) << sh;
    end
  end

  assign int_part   = ext[EXT_W-1:FRAC_W];
  assign mag_lo     = int_part[INT_W-1:0];
  assign mag_big    = too_big | (|int_part[SHIFT_MAX-1:INT_W-1]);
  assign mag_is_min = !too_big && (int_part == (SHIFT_MAX'(1) << (INT_W - 1)));
  assign frac_nz    = below_one | (|ext[FRAC_W-1:0]);
endmodule

// File: rtl/cvtw_pack.sv
module cvtw_pack
  import cvtw_pkg::*;
#(
  parameter int INT_W = TGT_INT_W,
  parameter int OUT_W = DST_W
) (
  input  fp_cls_e          cls,
  input  logic             sign,
  input  logic [INT_W-1:0] mag_lo,
  input  logic             mag_big,
  input  logic             mag_is_min,
  input  logic             frac_nz,
  output logic [OUT_W-1:0] res,
  output logic             invalid,
  output logic             inexact
);
  logic [INT_W-1:0] word;
  logic             ovf;

  always_comb begin
    word    = sign ? (~mag_lo + INT_W'(1)) : mag_lo;
    ovf     = mag_big && !(sign && mag_is_min);
    res     = {{(OUT_W-INT_W){word[INT_W-1]}}, word};
    invalid = ovf;
    inexact = !ovf && frac_nz;
    if (cls == CLS_SPEC) begin
      res     = '0;
      invalid = 1'b1;
      inexact = 1'b0;
    end
  end
endmodule

// File: rtl/cvtw_mod_int32.sv
module cvtw_mod_int32
  import cvtw_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W,
  parameter int INT_W  = TGT_INT_W,
  parameter int OUT_W  = DST_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [EXP_W+FRAC_W:0]   in_op,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_res,
  output logic                    out_invalid,
  output logic                    out_inexact
);
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  localparam int HUGE_EXP  = BIAS + FRAC_W + INT_W;

  logic [1:0] rst_sync;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  fp_cls_e                 cls;
  logic                    sign;
  logic signed [EXP_W+1:0] exp_unb;
  logic [FRAC_W:0]         sig;
  logic [INT_W-1:0]        mag_lo;
  logic                    mag_big, mag_is_min, frac_nz;
  logic [OUT_W-1:0]        res_c;
  logic                    inv_c, inx_c;

  cvtw_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .op(in_op), .cls(cls), .sign(sign), .exp_unb(exp_unb), .sig(sig));

  cvtw_wrap_shift #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_shift (
    .cls(cls), .exp_unb(exp_unb), .sig(sig), .mag_lo(mag_lo),
    .mag_big(mag_big), .mag_is_min(mag_is_min), .frac_nz(frac_nz));

  cvtw_pack #(.INT_W(INT_W), .OUT_W(OUT_W)) u_pack (
    .cls(cls), .sign(sign), .mag_lo(mag_lo), .mag_big(mag_big),
    .mag_is_min(mag_is_min), .frac_nz(frac_nz),
    .res(res_c), .invalid(inv_c), .inexact(inx_c));

  logic             vld_d;
  logic [OUT_W-1:0] res_d;
  logic             inv_d, inx_d;

  always_comb begin
    vld_d = in_valid;
    res_d = out_res;
    inv_d = out_invalid;
    inx_d = out_inexact;
    if (in_valid) begin
      res_d = res_c;
      inv_d = inv_c;
      inx_d = inx_c;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      out_valid   <= 1'b0;
      out_res     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid   <= vld_d;
      out_res     <= res_d;
      out_invalid <= inv_d;
      out_inexact <= inx_d;
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_ok_n)
    in_valid |=> out_valid);
  a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !in_valid |=> !out_valid);
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !in_valid |=> $stable(out_res) && $stable(out_invalid) && $stable(out_inexact));
  a_r5_nonfinite_zero: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && (&in_op[EXP_W+FRAC_W-1:FRAC_W])) |=>
      (out_res == '0) && out_invalid && !out_inexact);
  a_r6_zero_in: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && (in_op[EXP_W+FRAC_W-1:0] == '0)) |=>
      (out_res == '0) && !out_invalid && !out_inexact);
  a_r9_huge_zero: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && !(&in_op[EXP_W+FRAC_W-1:FRAC_W]) &&
     (in_op[EXP_W+FRAC_W-1:FRAC_W] >= EXP_W'(HUGE_EXP))) |=>
      (out_res == '0) && out_invalid);
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_ok_n)
    out_valid |-> !(out_invalid && out_inexact));
endmodule

// File: tb/tb_cvtw_mod_int32.sv
module tb_cvtw_mod_int32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic        out_valid;
  logic [63:0] out_res;
  logic        out_invalid, out_inexact;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cvtw_mod_int32 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_res(out_res),
    .out_invalid(out_invalid), .out_inexact(out_inexact));

  task automatic check(input string tag, input logic [63:0] er,
                       input logic ev, input logic ei, input logic ex);
    checks++;
    if (out_valid !== ev || out_res !== er || out_invalid !== ei || out_inexact !== ex) begin
      failures++;
      $display("FAIL %s: got v=%0b res=%h inv=%0b inx=%0b, expected v=%0b res=%h inv=%0b inx=%0b",
               tag, out_valid, out_res, out_invalid, out_inexact, ev, er, ei, ex);
    end
  endtask

  // expected outcome from exact truncated magnitude, sign, discarded fraction
  task automatic expect_from(input logic [191:0] mag, input logic neg, input logic fr,
                             output logic [63:0] er, output logic ei, output logic ex);
    logic [31:0] w;
    w  = neg ? (32'd0 - mag[31:0]) : mag[31:0];
    er = {{32{w[31]}}, w};
    ei = neg ? (mag > 192'h8000_0000) : (mag > 192'h7FFF_FFFF);
    ex = !ei && fr;
  endtask

  task automatic run(input string tag, input logic [63:0] op,
                     input logic [63:0] er, input logic ei, input logic ex);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, er, 1'b1, ei, ex);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] er;
    logic        ei, ex;
    logic [63:0] held;
    int unsigned mlist [4] = '{1, 3, 32'hFFFFF, 32'h12345};
    longint      nlist [7] = '{0, 1, 7, 64'h7FFF_FFFF, 64'h8000_0000, 64'h1_2345_6789, 64'h100_0000_0000};
    real         flist [3] = '{0.5, 0.25, 0.75};

    repeat (3) @(negedge clk);
    check("R11 reset state", 64'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 after release", 64'h0, 1'b0, 1'b0, 1'b0);

    // named corners
    run("R2 2^40+7", $realtobits(2.0**40 + 7.0), 64'd7, 1'b1, 1'b0);
    run("R4 R1 -1.5", $realtobits(-1.5), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    run("R1 2.75", $realtobits(2.75), 64'd2, 1'b0, 1'b1);
    run("R7 2^31", $realtobits(2.0**31), 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
    run("R7 -2^31", $realtobits(-(2.0**31)), 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0);
    run("R5 +inf", 64'h7FF0_0000_0000_0000, 64'h0, 1'b1, 1'b0);
    run("R5 -inf", 64'hFFF0_0000_0000_0000, 64'h0, 1'b1, 1'b0);
    run("R5 qNaN", 64'h7FF8_0000_0000_0000, 64'h0, 1'b1, 1'b0);
    run("R5 sNaN", 64'hFFF0_0000_0000_0001, 64'h0, 1'b1, 1'b0);
    run("R6 +0", 64'h0, 64'h0, 1'b0, 1'b0);
    run("R6 -0", 64'h8000_0000_0000_0000, 64'h0, 1'b0, 1'b0);
    run("R6 min subnormal", 64'h0000_0000_0000_0001, 64'h0, 1'b0, 1'b1);
    run("R6 max -subnormal", 64'h800F_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b1);
    run("R8 min normal", 64'h0010_0000_0000_0000, 64'h0, 1'b0, 1'b1);
    run("R9 2^84", $realtobits(2.0**84), 64'h0, 1'b1, 1'b0);
    run("R9 max finite", 64'hFFEF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0);
    run("R7 R3 2^32-1", $realtobits(2.0**32 - 1.0), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);

    // R10 hold while idle
    held = out_res;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_op = $realtobits(123.0 + real'(i));
    end
    check("R10 idle hold", held, 1'b0, 1'b1, 1'b0);

    // sweep A: scaled odd mantissas, both signs (R2 R3 R4 R7 R9)
    for (int k = 0; k <= 100; k++) begin
      for (int j = 0; j < 4; j++) begin
        for (int s = 0; s < 2; s++) begin
          logic [191:0] mag;
          real v;
          mag = 192'(mlist[j]) << k;
          v   = real'(mlist[j]) * (2.0 ** k);
          if (s == 1) v = -v;
          expect_from(mag, s[0], 1'b0, er, ei, ex);
          run("R2 R4 R7 sweep", $realtobits(v), er, ei, ex);
        end
      end
    end

    // sweep B: fractional offsets near boundaries (R1 R8 R7)
    for (int j = 0; j < 7; j++) begin
      for (int f = 0; f < 3; f++) begin
        for (int s = 0; s < 2; s++) begin
          real v;
          v = real'(nlist[j]) + flist[f];
          if (s == 1) v = -v;
          expect_from(192'(nlist[j]), s[0], 1'b1, er, ei, ex);
          run("R1 R8 fraction sweep", $realtobits(v), er, ei, ex);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule